// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block shares one 10-bit sampling converter among three requesters. One is a hardware real-time trigger and two are started by software. Each requester owns a 16-bit channel-select mask and a 16-bit averaging mask, both held in a byte-wide register space. When a requester is started, the sequencer latches its masks. It walks the selected channels from index 0 upward and requests one ADC sample per channel, or four samples when averaging is enabled. It writes each 10-bit result, left-justified, into a pair of byte registers.

The real-time requester writes its results into a bank of its own. The two software requesters share a second bank. Each software requester has a control byte that starts it and reports busy and end-of-conversion. When any request finishes, a per-requester interrupt status bit is set. The interrupt output is the OR of the status bits that are not masked. A global power-enable bit must be set before any request can start.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset all select, averaging, power and interrupt-status registers read 0, the interrupt mask at 0x0F reads 0x07, both control bytes read 0, all result bytes read 0 and `irq` is low.
- R2: The select/averaging masks are byte pairs, low byte first: real-time select 0x02, average 0x04; software-1 select 0x06, average 0x08; software-2 select 0x0A, average 0x0C. Bit 0 of 0x00 is power enable. All of these read back what was written.
- R3: Writing a control byte (0x12 for software-1, 0x13 for software-2) with bit 5 set makes bit 0 (busy) read 1 and bit 1 (end of conversion) read 0. On completion busy reads 0 and end of conversion reads 1. The two bits are never both 1.
- R4: While bit 0 of 0x00 is 0, a start write and the real-time trigger `rt_trig` are ignored: no busy, no ADC request, no status bit.
- R5: Only selected channels are converted, in ascending index order. `adc_req` stays high with `adc_chan` stable until a cycle with `adc_ack` high. Each such cycle delivers one sample on `adc_data`.
- R6: A channel whose averaging bit is set takes 4 samples, and its result is their sum shifted right by 2. Otherwise its result is the single sample.
- R7: The result of channel i is at base+2i (low byte) and base+2i+1 (high byte). The base is 0x17 for the real-time bank and 0x37 for the shared software bank. The high byte holds result[9:2]; the low byte holds result[1:0] in bits 7:6, with zeros below.
- R8: When several requesters are pending as the converter becomes free, the real-time requester goes first, then software-1, then software-2.
- R9: Completion sets interrupt-status bit n at 0x0E (n = 0 real-time, 1 software-1, 2 software-2). Writing 1 to a status bit clears it. `irq` is high when any status bit is set whose bit in the mask at 0x0F is 0.
- R10: A start write or `rt_trig` for a requester that is already busy is ignored and does not add a second conversion.
- R11: The masks are captured at start. Writing them during a conversion does not change that conversion.
- R12: A request with an empty select mask completes, setting its status and end of conversion, without any ADC request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| rt_trig | input | 1 | Real-time requester start pulse |
| adc_req | output | 1 | Sample request to the converter |
| adc_chan | output | 4 | Channel to sample |
| adc_ack | input | 1 | Sample delivered this cycle |
| adc_data | input | 10 | Sample value, valid with `adc_ack` |
| irq | output | 1 | Unmasked interrupt request |

## Verification
The bench builds the block with its default parameters: 16 channels, 10-bit samples and a four-sample averaging window. This makes the full left-justified byte layout and the shift-by-two averaging visible at the register port. With the full 16-channel software mask, one conversion lasts long enough that the other two requesters can be started while it runs. That brings the fixed priority order and the rejection of a second start within reach. The ADC responder answers after a varying delay, so requests that are held across several cycles are exercised.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int NCH      = 16;
  localparam int CHW      = $clog2(NCH);
  localparam int DW       = 10;
  localparam int NREQ     = 3;
  localparam int REQW     = $clog2(NREQ);
  localparam int AVG_LOG  = 2;
  localparam int AW       = 8;

  localparam int A_PWR    = 'h00;
  localparam int A_MASKS  = 'h02;  // stride 4 per requester: sel lo/hi, avg lo/hi
  localparam int A_ISTAT  = 'h0E;
  localparam int A_IMASK  = 'h0F;
  localparam int A_CTL    = 'h12;  // software requesters 1..NREQ-1
  localparam int A_RT_RES = 'h17;
  localparam int A_SW_RES = 'h37;

  localparam int CTL_START = 5;

  typedef enum logic [2:0] {
    E_IDLE, E_SCAN, E_SAMPLE, E_WRITE, E_DONE
  } eng_state_e;
endpackage

// File: rtl/adcseq_arb.sv
module adcseq_arb #(
  parameter int N = adcseq_pkg::NREQ,
  parameter int W = adcseq_pkg::REQW
) (
  input  logic [N-1:0] pend,
  output logic         vld,
  output logic [W-1:0] id
);
  // lowest index has highest priority
  always_comb begin
    vld = 1'b0;
    id  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        vld = 1'b1;
        id  = W'(i);
      end
    end
  end
endmodule

// File: rtl/adcseq_engine.sv
module adcseq_engine
  import adcseq_pkg::*;
#(
  parameter int NC  = NCH,
  parameter int CW  = CHW,
  parameter int SW  = DW,
  parameter int RW  = REQW,
  parameter int AL  = AVG_LOG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] start_id,
  input  logic [NC-1:0] sel,
  input  logic [NC-1:0] avg,
  output logic          adc_req,
  output logic [CW-1:0] adc_chan,
  input  logic          adc_ack,
  input  logic [SW-1:0] adc_data,
  output logic          res_we,
  output logic [RW-1:0] res_id,
  output logic [CW-1:0] res_ch,
  output logic [SW-1:0] res_val,
  output logic          done,
  output logic          idle
);
  localparam int ACCW = SW + AL;

  eng_state_e    st_q, st_n;
  logic [CW-1:0] idx_q, idx_n;
  logic [RW-1:0] id_q, id_n;
  logic [NC-1:0] sel_q, sel_n, avg_q, avg_n;
  logic [ACCW-1:0] acc_q, acc_n;
  logic [AL-1:0] cnt_q, cnt_n;
  logic          last_ch;

  assign last_ch = (idx_q == CW'(NC - 1));

  always_comb begin
    st_n  = st_q;
    idx_n = idx_q;
    id_n  = id_q;
    sel_n = sel_q;
    avg_n = avg_q;
    acc_n = acc_q;
    cnt_n = cnt_q;
    unique case (st_q)
      E_IDLE: begin
        if (start) begin
          id_n  = start_id;
          sel_n = sel;
          avg_n = avg;
          idx_n = '0;
          st_n  = E_SCAN;
        end
      end
      E_SCAN: begin
        if (sel_q[idx_q]) begin
          acc_n = '0;
          cnt_n = '0;
          st_n  = E_SAMPLE;
        end else if (last_ch) begin
          st_n = E_DONE;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      E_SAMPLE: begin
        if (adc_ack) begin
          acc_n = acc_q + ACCW'(adc_data);
          if (!avg_q[idx_q] || cnt_q == '1) st_n = E_WRITE;
          else cnt_n = cnt_q + 1'b1;
        end
      end
      E_WRITE: begin
        if (last_ch) begin
          st_n = E_DONE;
        end else begin
          idx_n = idx_q + 1'b1;
          st_n  = E_SCAN;
        end
      end
      E_DONE:  st_n = E_IDLE;
      default: st_n = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= E_IDLE;
      idx_q <= '0;
      id_q  <= '0;
      sel_q <= '0;
      avg_q <= '0;
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
      id_q  <= id_n;
      sel_q <= sel_n;
      avg_q <= avg_n;
      acc_q <= acc_n;
      cnt_q <= cnt_n;
    end
  end

  assign adc_req  = (st_q == E_SAMPLE);
  assign adc_chan = idx_q;
  assign res_we   = (st_q == E_WRITE);
  assign res_id   = id_q;
  assign res_ch   = idx_q;
  assign res_val  = avg_q[idx_q] ? acc_q[ACCW-1:AL] : acc_q[SW-1:0];
  assign done     = (st_q == E_DONE);
  assign idle     = (st_q == E_IDLE);
endmodule

// File: rtl/adcseq_results.sv
module adcseq_results
  import adcseq_pkg::*;
#(
  parameter int NC      = NCH,
  parameter int CW      = CHW,
  parameter int SW      = DW,
  parameter int A       = AW,
  parameter int RT_BASE = A_RT_RES,
  parameter int SW_BASE = A_SW_RES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          wr_rt,
  input  logic [CW-1:0] wr_ch,
  input  logic [SW-1:0] wr_val,
  input  logic [A-1:0]  rd_addr,
  output logic          rd_hit,
  output logic [7:0]    rd_byte
);
  localparam int NB   = 2;
  localparam int LOWB = SW - 8;

  logic [NB-1:0]       hit;
  logic [NB-1:0][7:0]  bytes;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int BASE = (b == 0) ? RT_BASE : SW_BASE;
    logic [SW-1:0] mem_q [NC];
    logic [A-1:0]  off;
    logic [SW-1:0] val;
    logic          bank_we;

    assign bank_we = we && (wr_rt == (b == 0));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int c = 0; c < NC; c++) mem_q[c] <= '0;
      end else if (bank_we) begin
        mem_q[wr_ch] <= wr_val;
      end
    end

    assign off      = rd_addr - A'(BASE);
    assign hit[b]   = (off < A'(2 * NC));
    assign val      = mem_q[off[CW:1]];
    assign bytes[b] = off[0] ? val[SW-1:SW-8]
                             : {val[LOWB-1:0], {(8 - LOWB){1'b0}}};
  end

  assign rd_hit  = |hit;
  assign rd_byte = hit[0] ? bytes[0] : (hit[1] ? bytes[1] : 8'h00);
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int NR = NREQ,
  parameter int NC = NCH,
  parameter int RW = REQW,
  parameter int A  = AW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [A-1:0]          addr,
  input  logic [7:0]            wdata,
  input  logic                  rt_trig,
  input  logic                  done,
  input  logic [RW-1:0]         done_id,
  output logic                  rd_hit,
  output logic [7:0]            rd_byte,
  output logic                  pwr,
  output logic [NR-1:0]         busy,
  output logic [NR-2:0]         eoc,
  output logic [NR-1:0][NC-1:0] sel,
  output logic [NR-1:0][NC-1:0] avg,
  output logic                  irq
);
  localparam int HB = NC / 2;

  logic                  pwr_q, pwr_n;
  logic [NR-1:0][NC-1:0] sel_q, sel_n, avg_q, avg_n;
  logic [NR-1:0]         busy_q, busy_n, ist_q, ist_n, msk_q, msk_n, start_req;
  logic [NR-2:0]         eoc_q, eoc_n;

  always_comb begin
    start_req[0] = rt_trig;
    for (int r = 1; r < NR; r++)
      start_req[r] = wr && (addr == A'(A_CTL + r - 1)) && wdata[CTL_START];
  end

  always_comb begin
    pwr_n  = pwr_q;
    sel_n  = sel_q;
    avg_n  = avg_q;
    busy_n = busy_q;
    eoc_n  = eoc_q;
    ist_n  = ist_q;
    msk_n  = msk_q;
    if (wr) begin
      if (addr == A'(A_PWR))   pwr_n = wdata[0];
      if (addr == A'(A_IMASK)) msk_n = wdata[NR-1:0];
      if (addr == A'(A_ISTAT)) ist_n = ist_q & ~wdata[NR-1:0];
      for (int r = 0; r < NR; r++) begin
        if (addr == A'(A_MASKS + 4 * r))     sel_n[r][HB-1:0]  = wdata;
        if (addr == A'(A_MASKS + 4 * r + 1)) sel_n[r][NC-1:HB] = wdata;
        if (addr == A'(A_MASKS + 4 * r + 2)) avg_n[r][HB-1:0]  = wdata;
        if (addr == A'(A_MASKS + 4 * r + 3)) avg_n[r][NC-1:HB] = wdata;
      end
    end
    for (int r = 0; r < NR; r++)
      if (start_req[r] && pwr_q && !busy_q[r]) busy_n[r] = 1'b1;
    for (int r = 1; r < NR; r++)
      if (start_req[r] && pwr_q && !busy_q[r]) eoc_n[r-1] = 1'b0;
    if (done) begin
      busy_n[done_id] = 1'b0;
      ist_n[done_id]  = 1'b1;
    end
    for (int r = 1; r < NR; r++)
      if (done && done_id == RW'(r)) eoc_n[r-1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      sel_q  <= '0;
      avg_q  <= '0;
      busy_q <= '0;
      eoc_q  <= '0;
      ist_q  <= '0;
      msk_q  <= '1;
    end else begin
      pwr_q  <= pwr_n;
      sel_q  <= sel_n;
      avg_q  <= avg_n;
      busy_q <= busy_n;
      eoc_q  <= eoc_n;
      ist_q  <= ist_n;
      msk_q  <= msk_n;
    end
  end

  always_comb begin
    rd_hit  = 1'b0;
    rd_byte = 8'h00;
    if (addr == A'(A_PWR)) begin
      rd_hit  = 1'b1;
      rd_byte = {7'b0, pwr_q};
    end
    if (addr == A'(A_ISTAT)) begin
      rd_hit  = 1'b1;
      rd_byte = {{(8 - NR){1'b0}}, ist_q};
    end
    if (addr == A'(A_IMASK)) begin
      rd_hit  = 1'b1;
      rd_byte = {{(8 - NR){1'b0}}, msk_q};
    end
    for (int r = 0; r < NR; r++) begin
      if (addr == A'(A_MASKS + 4 * r))     begin rd_hit = 1'b1; rd_byte = sel_q[r][HB-1:0];  end
      if (addr == A'(A_MASKS + 4 * r + 1)) begin rd_hit = 1'b1; rd_byte = sel_q[r][NC-1:HB]; end
      if (addr == A'(A_MASKS + 4 * r + 2)) begin rd_hit = 1'b1; rd_byte = avg_q[r][HB-1:0];  end
      if (addr == A'(A_MASKS + 4 * r + 3)) begin rd_hit = 1'b1; rd_byte = avg_q[r][NC-1:HB]; end
    end
    for (int r = 1; r < NR; r++) begin
      if (addr == A'(A_CTL + r - 1)) begin
        rd_hit  = 1'b1;
        rd_byte = {6'b0, eoc_q[r-1], busy_q[r]};
      end
    end
  end

  assign pwr  = pwr_q;
  assign busy = busy_q;
  assign eoc  = eoc_q;
  assign sel  = sel_q;
  assign avg  = avg_q;
  assign irq  = |(ist_q & ~msk_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adcseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  reg_addr,
  input  logic           reg_wr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic           rt_trig,
  output logic           adc_req,
  output logic [CHW-1:0] adc_chan,
  input  logic           adc_ack,
  input  logic [DW-1:0]  adc_data,
  output logic           irq
);
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  logic                      pwr_on;
  logic [NREQ-1:0]           req_busy;
  logic [NREQ-2:0]           ctl_eoc;
  logic [NREQ-1:0][NCH-1:0]  req_sel, req_avg;
  logic                      arb_vld, grant, eng_idle, eng_done;
  logic [REQW-1:0]           gnt_id, res_id;
  logic                      res_we;
  logic [CHW-1:0]            res_ch;
  logic [DW-1:0]             res_val;
  logic                      reg_hit, res_hit;
  logic [7:0]                reg_byte, res_byte;

  adcseq_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rt_trig (rt_trig),
    .done    (eng_done),
    .done_id (res_id),
    .rd_hit  (reg_hit),
    .rd_byte (reg_byte),
    .pwr     (pwr_on),
    .busy    (req_busy),
    .eoc     (ctl_eoc),
    .sel     (req_sel),
    .avg     (req_avg),
    .irq     (irq)
  );

  adcseq_arb u_arb (
    .pend (req_busy),
    .vld  (arb_vld),
    .id   (gnt_id)
  );

  assign grant = arb_vld && eng_idle && pwr_on;

  adcseq_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (grant),
    .start_id (gnt_id),
    .sel      (req_sel[gnt_id]),
    .avg      (req_avg[gnt_id]),
    .adc_req  (adc_req),
    .adc_chan (adc_chan),
    .adc_ack  (adc_ack),
    .adc_data (adc_data),
    .res_we   (res_we),
    .res_id   (res_id),
    .res_ch   (res_ch),
    .res_val  (res_val),
    .done     (eng_done),
    .idle     (eng_idle)
  );

  adcseq_results u_res (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (res_we),
    .wr_rt   (res_id == '0),
    .wr_ch   (res_ch),
    .wr_val  (res_val),
    .rd_addr (reg_addr),
    .rd_hit  (res_hit),
    .rd_byte (res_byte)
  );

  assign reg_rdata = res_hit ? res_byte : (reg_hit ? reg_byte : 8'h00);
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk
  import adcseq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            adc_req,
  input logic            adc_ack,
  input logic [CHW-1:0]  adc_chan,
  input logic            pwr_on,
  input logic            eng_idle,
  input logic            eng_done,
  input logic [REQW-1:0] res_id,
  input logic [NREQ-1:0] req_busy,
  input logic [NREQ-2:0] ctl_eoc,
  input logic            grant,
  input logic [REQW-1:0] gnt_id
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req && !adc_ack |=> adc_req && $stable(adc_chan)); // R5

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> !adc_req); // R5

  AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle && !pwr_on |=> eng_idle); // R4

  AST_BUSY_EOC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_busy[1] && ctl_eoc[0]) && !(req_busy[2] && ctl_eoc[1])); // R3

  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> req_busy[res_id]); // R3

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_busy[1] && !(eng_done && res_id == 2'd1) |=> req_busy[1]); // R10

  AST_RT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    grant && req_busy[0] |-> gnt_id == 2'd0); // R8

  AST_SW1_BEFORE_SW2: assert property (@(posedge clk) disable iff (!rst_n)
    grant && req_busy[1] && !req_busy[0] |-> gnt_id == 2'd1); // R8
endmodule

bind adc_seq_ctrl adcseq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .adc_req  (adc_req),
  .adc_ack  (adc_ack),
  .adc_chan (adc_chan),
  .pwr_on   (pwr_on),
  .eng_idle (eng_idle),
  .eng_done (eng_done),
  .res_id   (res_id),
  .req_busy (req_busy),
  .ctl_eoc  (ctl_eoc),
  .grant    (grant),
  .gnt_id   (gnt_id)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rt_trig = 1'b0;
  logic       adc_req;
  logic [3:0] adc_chan;
  logic       adc_ack = 1'b0;
  logic [9:0] adc_data = '0;
  logic       irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rt_trig(rt_trig),
    .adc_req(adc_req), .adc_chan(adc_chan), .adc_ack(adc_ack),
    .adc_data(adc_data), .irq(irq)
  );

  int tests = 0;
  int fails = 0;
  bit live = 0;
  bit ended = 0;

  // reference model: expected conversion queue and result banks
  int q_ch[$];
  int q_bank[$];
  int q_n[$];
  int exp_rt[16];
  int exp_sw[16];
  int acc = 0, scnt = 0, dly = 0, kglob = 0;

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic push_job(input int bank, input int selm, input int avgm);
    for (int c = 0; c < 16; c++) begin
      if (selm[c]) begin
        q_ch.push_back(c);
        q_bank.push_back(bank);
        q_n.push_back(avgm[c] ? 4 : 1);
      end
    end
  endtask

  // ADC responder and per-cycle comparison against the model
  always @(negedge clk) begin
    adc_ack = 1'b0;
    if (live && adc_req) begin
      if (q_ch.size() == 0) begin
        chk("R5 request with no expected conversion", int'(adc_chan), -1);
      end else if (dly > 0) begin
        dly--;
      end else begin
        int d;
        chk("R5 channel order", int'(adc_chan), q_ch[0]);
        d = (q_ch[0] * 53 + kglob * 29 + 11) % 1024;
        adc_data = 10'(d);
        adc_ack = 1'b1;
        acc += d;
        scnt++;
        kglob++;
        dly = kglob % 3;
        if (scnt == q_n[0]) begin
          int r;
          r = (q_n[0] == 4) ? (acc >> 2) : acc;
          if (q_bank[0] == 0) exp_rt[q_ch[0]] = r;
          else exp_sw[q_ch[0]] = r;
          void'(q_ch.pop_front());
          void'(q_bank.pop_front());
          void'(q_n.pop_front());
          acc = 0;
          scnt = 0;
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 8'(a);
    reg_wdata = 8'(d);
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 8'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    int v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse_rt(input int cycles);
    @(negedge clk);
    rt_trig = 1'b1;
    repeat (cycles - 1) @(negedge clk);
    @(negedge clk);
    rt_trig = 1'b0;
  endtask

  task automatic wait_stat(input int b, input string tag);
    int v;
    bit seen;
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      rd('h0E, v);
      if (v[b]) seen = 1;
    end
    chk(tag, int'(seen), 1);
  endtask

  task automatic chk_res(input int bank, input int ch, input string tag);
    int base, e;
    base = bank ? 'h37 : 'h17;
    e = bank ? exp_sw[ch] : exp_rt[ch];
    rd_chk({tag, " low byte"}, base + 2 * ch, (e & 3) << 6);
    rd_chk({tag, " high byte"}, base + 2 * ch + 1, e >> 2);
  endtask

  initial begin
    int v;
    for (int i = 0; i < 16; i++) begin exp_rt[i] = 0; exp_sw[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1;

    // R1 reset state
    for (int a = 'h00; a <= 'h0E; a++) if (a != 1) rd_chk("R1 reset register zero", a, 0);
    rd_chk("R1 mask reset", 'h0F, 'h07);
    rd_chk("R1 ctl1 reset", 'h12, 0);
    rd_chk("R1 ctl2 reset", 'h13, 0);
    rd_chk("R1 rt result reset", 'h17 + 9, 0);
    rd_chk("R1 sw result reset", 'h37 + 30, 0);
    #1 chk("R1 irq low", int'(irq), 0);

    // R2 read back
    wr('h06, 'hA5); wr('h07, 'h3C); wr('h0C, 'h5A);
    rd_chk("R2 sw1 select low", 'h06, 'hA5);
    rd_chk("R2 sw1 select high", 'h07, 'h3C);
    rd_chk("R2 sw2 average low", 'h0C, 'h5A);
    wr('h0C, 0);

    // R4 power off: starts ignored
    wr('h12, 'h20);
    rd_chk("R4 start ignored while powered off", 'h12, 0);
    pulse_rt(1);
    repeat (30) @(negedge clk);
    rd_chk("R4 no status while powered off", 'h0E, 0);
    wr('h00, 1);
    rd_chk("R2 power bit", 'h00, 1);

    // SW1 conversion with averaging on ch5
    wr('h06, 'h21); wr('h07, 'h84); wr('h08, 'h20); wr('h09, 'h00);
    push_job(1, 'h8421, 'h0020);
    wr('h12, 'h20);
    rd_chk("R3 busy after start", 'h12, 'h01);
    wr('h12, 'h20);                         // R10 second start ignored
    wr('h06, 'hFF); wr('h07, 'hFF);          // R11 mask change ignored
    wr('h08, 'hFF);
    wait_stat(1, "R3 sw1 completes");
    rd_chk("R3 done: busy clear, eoc set", 'h12, 'h02);
    chk("R10 no extra conversion queued", q_ch.size(), 0);
    chk_res(1, 0, "R7 sw ch0");
    chk_res(1, 5, "R6 sw ch5 averaged");
    chk_res(1, 10, "R5 sw ch10");
    chk_res(1, 15, "R11 sw ch15");
    chk_res(1, 1, "R11 unselected ch1 untouched");

    // R9 interrupt masking and clearing
    rd_chk("R9 status bit1", 'h0E, 'h02);
    #1 chk("R9 irq masked", int'(irq), 0);
    wr('h0F, 'h05);
    #1 chk("R9 irq unmasked", int'(irq), 1);
    wr('h0E, 'h02);
    rd_chk("R9 write-one clears", 'h0E, 0);
    #1 chk("R9 irq low after clear", int'(irq), 0);
    wr('h0F, 'h07);

    // real-time requester, double trigger
    wr('h02, 'h03); wr('h03, 0); wr('h04, 'h02); wr('h05, 0);
    push_job(0, 'h0003, 'h0002);
    pulse_rt(2);
    wait_stat(0, "R10 rt completes once");
    repeat (40) @(negedge clk);
    chk("R10 rt retrigger ignored", q_ch.size(), 0);
    chk_res(0, 0, "R7 rt ch0");
    chk_res(0, 1, "R6 rt ch1 averaged");
    chk_res(1, 0, "R7 sw bank untouched by rt");
    wr('h0E, 'h01);

    // R12 empty mask on SW2
    wr('h13, 'h20);
    wait_stat(2, "R12 empty request completes");
    rd_chk("R12 eoc set", 'h13, 'h02);
    wr('h0E, 'h04);

    // R8 priority: SW2 long job, then SW1 and RT pending
    wr('h0A, 'hFF); wr('h0B, 'hFF);
    push_job(1, 'hFFFF, 0);
    wr('h13, 'h20);
    wr('h02, 'h10); wr('h04, 0);
    wr('h06, 'h00); wr('h07, 'h01); wr('h08, 0);
    push_job(0, 'h0010, 0);
    push_job(1, 'h0100, 0);
    wr('h12, 'h20);
    pulse_rt(1);
    wait_stat(1, "R8 sw1 completes last");
    rd_chk("R8 all three done", 'h0E, 'h07);
    chk("R8 queue drained", q_ch.size(), 0);
    chk_res(0, 4, "R8 rt ch4");
    chk_res(1, 8, "R8 sw1 ch8 overwrote sw2");
    chk_res(1, 7, "R8 sw2 ch7");

    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule